// File: doc/BRIEF.md
# Scoreboard In-Order Issue Controller

This block sits between instruction decode and the execution units of a small in-order machine with eight architectural registers. Every cycle it looks at the one decoded instruction on its input, which names two source registers, one destination register and an operation class. It decides whether that instruction may issue. An instruction is held back when one of its sources still awaits a result (read-after-write), when its destination still awaits a result (write-after-write), or when its destination is still being read by an instruction issued earlier (write-after-read). A held instruction raises `stall`, which tells decode to keep the same instruction on the input and to stop pulling from fetch.

Each register has its own writer state machine: `ST_FREE`, `ST_EX_ALU` (add/sub executing), `ST_EX_MUL` (multiply executing), `ST_MUL_2` (second multiply cycle), `ST_WB_ALU` and `ST_WB_MUL` (result written back this cycle). Issuing an add or sub moves the destination register from `ST_FREE` to `ST_EX_ALU`, then to `ST_WB_ALU`, then back to `ST_FREE`. Issuing a multiply moves it from `ST_FREE` to `ST_EX_MUL`, then `ST_MUL_2`, then `ST_WB_MUL`, then `ST_FREE`. Each register also keeps a small saturating count of the issued instructions that still have to read it. The count rises at issue and falls at the end of the cycle in which that reader starts execution. Writebacks are reported on two ports, one per latency class, so a short result and a long result that land in the same cycle are both visible.

Top module: `scb_issue_ctrl`

## Requirements
- R1: After reset, with no valid input, `issue`, `stall`, `wb_alu_valid` and `wb_mul_valid` are all 0 and no register is pending.
- R2: `issue` is 1 exactly when `in_valid` is 1 and no hazard exists. `stall` is 1 exactly when `in_valid` is 1 and `issue` is 0. With `in_valid` at 0 both are 0, even while results are pending.
- R3: Op codes: 0 = add and 1 = sub are short-class; 2 = multiply is long-class; 3 is treated as short-class. A short-class instruction issued in cycle N raises `wb_alu_valid` with `wb_alu_reg` equal to its destination in cycle N+2 only.
- R4: A multiply issued in cycle N raises `wb_mul_valid` with `wb_mul_reg` equal to its destination in cycle N+3 and in no earlier cycle.
- R5: Read-after-write: an instruction whose source matches a pending destination stalls through the writeback cycle. It issues at the earliest in cycle N+3 behind a short-class producer issued in cycle N, and in cycle N+4 behind a multiply issued in cycle N.
- R6: Write-after-read: an instruction whose destination is a source of the instruction issued in the previous cycle stalls for exactly one cycle.
- R7: Write-after-write: an instruction whose destination is pending stalls until the cycle after that destination's writeback, and then reports its own writeback on its own class port.
- R8: A multiply and a short-class instruction whose writebacks fall in the same cycle are both reported in that cycle, on the two ports.
- R9: A stalled instruction held on the input issues once its hazard clears, and its writeback is reported exactly once.
- R10: Independent instructions issue on consecutive cycles without any stall.
- R11: An instruction that names the same register as both sources counts as two readers, and both are released together one cycle after its issue.
- R12: An instruction whose destination equals one of its own sources issues without stalling on itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_op | input | 2 | Operation class code (0 add, 1 sub, 2 mul, 3 short) |
| in_src_a | input | 3 | First source register |
| in_src_b | input | 3 | Second source register |
| in_dst | input | 3 | Destination register |
| issue | output | 1 | Instruction accepted this cycle |
| stall | output | 1 | Instruction held; decode must keep it |
| wb_alu_valid | output | 1 | Short-class writeback this cycle |
| wb_alu_reg | output | 3 | Register of the short-class writeback |
| wb_mul_valid | output | 1 | Multiply writeback this cycle |
| wb_mul_reg | output | 3 | Register of the multiply writeback |

## Verification
The issue logic is driven with independent back-to-back instructions, which shows that no hazard is raised where none exists. It is then driven with dependent pairs of each kind: a source behind a short producer, a source behind a multiply, a destination behind a reader, a destination with duplicated sources behind a reader, and a destination behind a pending multiply. The cycle in which each pair finally issues separates the three hazard checks and the two release latencies. A multiply followed by an add exercises the shared writeback cycle, and a self-referencing instruction shows that an instruction never blocks on its own operands.

// File: rtl/scb_pkg.sv
package scb_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_RSV = 2'd3
    } op_e;

    // Writer state of one architectural register
    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_EX_ALU = 3'd1,
        ST_EX_MUL = 3'd2,
        ST_MUL_2  = 3'd3,
        ST_WB_ALU = 3'd4,
        ST_WB_MUL = 3'd5
    } wr_state_e;

    function automatic logic is_long(input logic [1:0] op);
        return op == OP_MUL;
    endfunction

endpackage

// File: rtl/scb_reg_track.sv
module scb_reg_track
    import scb_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_alu,
    input  logic       set_mul,
    input  logic [1:0] rd_inc,
    input  logic [1:0] rd_dec,
    output logic       wr_pend,
    output logic       wb_alu,
    output logic       wb_mul,
    output logic       rd_busy
);

    localparam int SUM_W = CNT_W + 2;
    localparam logic [SUM_W-1:0] CMAX = SUM_W'((1 << CNT_W) - 1);

    wr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE: begin
                if (set_mul)      state_d = ST_EX_MUL;
                else if (set_alu) state_d = ST_EX_ALU;
            end
            ST_EX_ALU: state_d = ST_WB_ALU;
            ST_EX_MUL: state_d = ST_MUL_2;
            ST_MUL_2:  state_d = ST_WB_MUL;
            ST_WB_ALU: state_d = ST_FREE;
            ST_WB_MUL: state_d = ST_FREE;
            default:   state_d = ST_FREE;
        endcase
    end

    always_comb begin
        sum = SUM_W'(cnt_q) + SUM_W'(rd_inc);
        if (sum < SUM_W'(rd_dec)) sum = '0;
        else                      sum = sum - SUM_W'(rd_dec);
        if (sum > CMAX) sum = CMAX;
        cnt_d = sum[CNT_W-1:0];
    end

    always_comb begin
        wr_pend = (state_q != ST_FREE);
        wb_alu  = (state_q == ST_WB_ALU);
        wb_mul  = (state_q == ST_WB_MUL);
        rd_busy = (cnt_q != '0);
    end

endmodule

// File: rtl/scb_hazard.sv
module scb_hazard #(
    parameter int NREG = 8,
    parameter int RW   = 3
) (
    input  logic [NREG-1:0] wr_pend,
    input  logic [NREG-1:0] rd_busy,
    input  logic            valid,
    input  logic [RW-1:0]   src_a,
    input  logic [RW-1:0]   src_b,
    input  logic [RW-1:0]   dst,
    output logic            issue,
    output logic            stall
);

    logic raw, war, waw;

    always_comb begin
        raw   = wr_pend[src_a] | wr_pend[src_b];
        war   = rd_busy[dst];
        waw   = wr_pend[dst];
        issue = valid & ~(raw | war | waw);
        stall = valid & ~issue;
    end

endmodule

// File: rtl/scb_wb_sel.sv
module scb_wb_sel #(
    parameter int NREG = 8,
    parameter int RW   = 3
) (
    input  logic [NREG-1:0] hot,
    output logic            valid,
    output logic [RW-1:0]   idx
);

    always_comb begin
        valid = |hot;
        idx   = '0;
        for (int k = 0; k < NREG; k++) begin
            if (hot[k]) idx = idx | RW'(k);
        end
    end

endmodule

// File: rtl/scb_issue_ctrl.sv
module scb_issue_ctrl
    import scb_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int CNT_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_op,
    input  logic [$clog2(NREG)-1:0] in_src_a,
    input  logic [$clog2(NREG)-1:0] in_src_b,
    input  logic [$clog2(NREG)-1:0] in_dst,
    output logic                    issue,
    output logic                    stall,
    output logic                    wb_alu_valid,
    output logic [$clog2(NREG)-1:0] wb_alu_reg,
    output logic                    wb_mul_valid,
    output logic [$clog2(NREG)-1:0] wb_mul_reg
);

    localparam int RW = $clog2(NREG);

    logic [NREG-1:0] wr_pend, rd_busy, wb_alu_hot, wb_mul_hot;

    // Execute-start stage: sources read by the instruction issued last cycle
    logic          ex_valid_q;
    logic [RW-1:0] ex_src_a_q, ex_src_b_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_valid_q <= 1'b0;
            ex_src_a_q <= '0;
            ex_src_b_q <= '0;
        end else begin
            ex_valid_q <= issue;
            ex_src_a_q <= in_src_a;
            ex_src_b_q <= in_src_b;
        end
    end

    scb_hazard #(.NREG(NREG), .RW(RW)) u_hazard (
        .wr_pend (wr_pend),
        .rd_busy (rd_busy),
        .valid   (in_valid),
        .src_a   (in_src_a),
        .src_b   (in_src_b),
        .dst     (in_dst),
        .issue   (issue),
        .stall   (stall)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [RW-1:0] IDX = RW'(g);
        logic [1:0] inc, dec;
        logic       hit_dst;

        always_comb begin
            hit_dst = issue && (in_dst == IDX);
            inc = {1'b0, issue && (in_src_a == IDX)}
                + {1'b0, issue && (in_src_b == IDX)};
            dec = {1'b0, ex_valid_q && (ex_src_a_q == IDX)}
                + {1'b0, ex_valid_q && (ex_src_b_q == IDX)};
        end

        scb_reg_track #(.CNT_W(CNT_W)) u_track (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_alu (hit_dst && !is_long(in_op)),
            .set_mul (hit_dst && is_long(in_op)),
            .rd_inc  (inc),
            .rd_dec  (dec),
            .wr_pend (wr_pend[g]),
            .wb_alu  (wb_alu_hot[g]),
            .wb_mul  (wb_mul_hot[g]),
            .rd_busy (rd_busy[g])
        );
    end

    scb_wb_sel #(.NREG(NREG), .RW(RW)) u_wb_alu (
        .hot   (wb_alu_hot),
        .valid (wb_alu_valid),
        .idx   (wb_alu_reg)
    );

    scb_wb_sel #(.NREG(NREG), .RW(RW)) u_wb_mul (
        .hot   (wb_mul_hot),
        .valid (wb_mul_valid),
        .idx   (wb_mul_reg)
    );

endmodule

// File: rtl/scb_issue_chk.sv
module scb_issue_chk #(
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [1:0]    in_op,
    input logic [RW-1:0] in_src_a,
    input logic [RW-1:0] in_src_b,
    input logic [RW-1:0] in_dst,
    input logic          issue,
    input logic          stall,
    input logic          wb_alu_valid,
    input logic [RW-1:0] wb_alu_reg,
    input logic          wb_mul_valid,
    input logic [RW-1:0] wb_mul_reg
);

    // R2
    issue_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue || stall) |-> (in_valid && !(issue && stall)));

    // R3
    alu_wb_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_op != 2'd2) |=> ##1 (wb_alu_valid && wb_alu_reg == $past(in_dst, 2)));

    // R4
    mul_wb_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && in_op == 2'd2) |=> ##2 (wb_mul_valid && wb_mul_reg == $past(in_dst, 3)));

    // R5
    raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue) && ($past(in_dst) == in_src_a || $past(in_dst) == in_src_b)) |-> !issue);

    // R6
    war_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue) && ($past(in_src_a) == in_dst || $past(in_src_b) == in_dst)) |-> !issue);

    // R7
    waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(issue) && $past(in_dst) == in_dst) |-> !issue);

endmodule

bind scb_issue_ctrl scb_issue_chk #(.RW($clog2(NREG))) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_src_a     (in_src_a),
    .in_src_b     (in_src_b),
    .in_dst       (in_dst),
    .issue        (issue),
    .stall        (stall),
    .wb_alu_valid (wb_alu_valid),
    .wb_alu_reg   (wb_alu_reg),
    .wb_mul_valid (wb_mul_valid),
    .wb_mul_reg   (wb_mul_reg)
);

// File: tb/scb_issue_ctrl_bench.sv
`timescale 1ns/1ps
module scb_issue_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_op = 2'd0;
    logic [2:0] in_src_a = 3'd0, in_src_b = 3'd0, in_dst = 3'd0;
    logic       issue, stall, wb_alu_valid, wb_mul_valid;
    logic [2:0] wb_alu_reg, wb_mul_reg;

    int checks = 0;
    int failures = 0;

    localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2;

    always #2.5 clk = ~clk;

    scb_issue_ctrl u_scb_issue_ctrl (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_src_a (in_src_a), .in_src_b (in_src_b), .in_dst (in_dst),
        .issue (issue), .stall (stall),
        .wb_alu_valid (wb_alu_valid), .wb_alu_reg (wb_alu_reg),
        .wb_mul_valid (wb_mul_valid), .wb_mul_reg (wb_mul_reg)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Present one input for one cycle; outputs are read 1 ns after the falling edge
    task automatic step(input logic v, input logic [1:0] op,
                        input logic [2:0] a, input logic [2:0] b, input logic [2:0] d);
        @(negedge clk);
        in_valid = v; in_op = op; in_src_a = a; in_src_b = b; in_dst = d;
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1", "issue", issue, 0);
        chk("R1", "stall", stall, 0);
        chk("R1", "wb_alu_valid", wb_alu_valid, 0);
        chk("R1", "wb_mul_valid", wb_mul_valid, 0);
        step(1'b1, ADD, 3'd0, 3'd1, 3'd2);
        chk("R1", "no pending register after reset", issue, 1);
        idle(4);
    endtask

    task automatic t_back_to_back();
        step(1'b1, ADD, 3'd2, 3'd3, 3'd1);
        chk("R10", "first issue", issue, 1);
        step(1'b1, SUB, 3'd5, 3'd6, 3'd4);
        chk("R10", "second issue", issue, 1);
        chk("R10", "no stall", stall, 0);
        chk("R3", "no wb one cycle after", wb_alu_valid, 0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R3", "add wb valid", wb_alu_valid, 1);
        chk("R3", "add wb reg", wb_alu_reg, 1);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R3", "sub wb valid", wb_alu_valid, 1);
        chk("R3", "sub wb reg", wb_alu_reg, 4);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R3", "wb only once", wb_alu_valid, 0);
        idle(2);
    endtask

    task automatic t_mul();
        step(1'b1, MUL, 3'd0, 3'd1, 3'd2);
        chk("R4", "mul issue", issue, 1);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R2", "no stall without valid", stall, 0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R4", "no mul wb at N+2", wb_mul_valid, 0);
        chk("R4", "no alu wb for mul", wb_alu_valid, 0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R4", "mul wb valid at N+3", wb_mul_valid, 1);
        chk("R4", "mul wb reg", wb_mul_reg, 2);
        idle(3);
    endtask

    task automatic t_raw_add();
        step(1'b1, ADD, 3'd1, 3'd2, 3'd3);
        chk("R5", "producer issue", issue, 1);
        step(1'b1, ADD, 3'd3, 3'd4, 3'd5);
        chk("R5", "stall N+1", stall, 1);
        chk("R5", "no issue N+1", issue, 0);
        step(1'b1, ADD, 3'd3, 3'd4, 3'd5);
        chk("R5", "stall in wb cycle", stall, 1);
        step(1'b1, ADD, 3'd3, 3'd4, 3'd5);
        chk("R9", "held instr issues N+3", issue, 1);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R9", "held instr wb valid", wb_alu_valid, 1);
        chk("R9", "held instr wb reg", wb_alu_reg, 5);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R9", "held instr wb once", wb_alu_valid, 0);
        idle(2);
    endtask

    task automatic t_raw_mul();
        step(1'b1, MUL, 3'd0, 3'd1, 3'd3);
        chk("R5", "mul producer issue", issue, 1);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, ADD, 3'd2, 3'd3, 3'd6);
            chk("R5", "stall behind mul", stall, 1);
        end
        step(1'b1, ADD, 3'd2, 3'd3, 3'd6);
        chk("R5", "issue at N+4 behind mul", issue, 1);
        idle(4);
    endtask

    task automatic t_war();
        step(1'b1, ADD, 3'd6, 3'd7, 3'd1);
        chk("R6", "reader issue", issue, 1);
        step(1'b1, ADD, 3'd2, 3'd2, 3'd6);
        chk("R6", "war stall", stall, 1);
        step(1'b1, ADD, 3'd2, 3'd2, 3'd6);
        chk("R6", "issue after one cycle", issue, 1);
        idle(4);
    endtask

    task automatic t_war_dup();
        step(1'b1, ADD, 3'd5, 3'd5, 3'd1);
        chk("R11", "dup reader issue", issue, 1);
        step(1'b1, ADD, 3'd0, 3'd0, 3'd5);
        chk("R11", "war stall on dup", stall, 1);
        step(1'b1, ADD, 3'd0, 3'd0, 3'd5);
        chk("R11", "both reads released", issue, 1);
        idle(4);
    endtask

    task automatic t_waw();
        step(1'b1, MUL, 3'd0, 3'd1, 3'd4);
        chk("R7", "first writer issue", issue, 1);
        for (int k = 0; k < 3; k++) begin
            step(1'b1, ADD, 3'd2, 3'd3, 3'd4);
            chk("R7", "waw stall", stall, 1);
        end
        step(1'b1, ADD, 3'd2, 3'd3, 3'd4);
        chk("R7", "issue after mul wb", issue, 1);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R7", "second writer wb port", wb_alu_valid, 1);
        chk("R7", "second writer wb reg", wb_alu_reg, 4);
        idle(3);
    endtask

    task automatic t_both_wb();
        step(1'b1, MUL, 3'd0, 3'd0, 3'd2);
        chk("R8", "mul issue", issue, 1);
        step(1'b1, ADD, 3'd1, 3'd1, 3'd3);
        chk("R8", "add issue", issue, 1);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        step(1'b0, ADD, 3'd0, 3'd0, 3'd0);
        chk("R8", "alu wb valid", wb_alu_valid, 1);
        chk("R8", "alu wb reg", wb_alu_reg, 3);
        chk("R8", "mul wb valid", wb_mul_valid, 1);
        chk("R8", "mul wb reg", wb_mul_reg, 2);
        idle(3);
    endtask

    task automatic t_self();
        step(1'b1, ADD, 3'd7, 3'd1, 3'd7);
        chk("R12", "self-referencing issue", issue, 1);
        chk("R12", "no self stall", stall, 0);
        idle(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_back_to_back();
        t_mul();
        t_raw_add();
        t_raw_mul();
        t_war();
        t_war_dup();
        t_waw();
        t_both_wb();
        t_self();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule